// File: doc/BRIEF.md
# Sensor-Gated Reset Sequencer

This block stands between the chip's reset pins and the processor core. It keeps the core from executing until an environmental sensor, such as a low-clock-frequency detector, has shown that it still works. A request on the external reset line does not reset the core directly. Instead it puts the sensor into a self-test. Only a sensor response during that test raises the internal reset. Raising the internal reset ends the self-test.

While the internal reset is active, the bus and control lines are clamped to zero. One final cycle then reads the bus back to confirm that the clamp really took hold. The core is released only if the bus reads back all zeros. A sensor that stays silent through the test window, or a bus that is not clean on readback, locks the block into a permanent alarm. Only a power cycle clears that alarm. During normal execution a sensor trip sends the core straight back into a clamped internal reset.

The power-on reset `por_n` stands for the power cycle. The sensor is modelled as one input, `sens_trip`, which is high whenever the sensor reports its condition. The sensor reports that condition both when the self-test forces it and when a real event occurs.

Top module: `sensor_reset_seq`

## Requirements
- R1: While `por_n` is low and after it rises, the block idles with all five outputs low. It stays there, ignoring `sens_trip` and `bus_rb`, until `ext_rst` is sampled high.
- R2: A rising clock edge that samples `ext_rst` high in the idle state starts the self-test. `test_en` goes high after that edge, and `int_rst` stays low while the test runs.
- R3: An edge that samples `sens_trip` high during the self-test ends the test. `test_en` falls and `int_rst` rises at that same edge.
- R4: `int_rst` stays high for `RST_CYCLES` edges of the reset phase plus one readback cycle, so `RST_CYCLES`+1 cycles in total (5 with defaults).
- R5: `bus_clamp` is high in every cycle in which `int_rst` is high.
- R6: The readback is decided by `bus_rb` in the last cycle of `int_rst` only. An all-zero value raises `run_en` at the next edge. Any nonzero value raises `alarm` instead.
- R7: If `sens_trip` is not sampled high on any of the `TIMEOUT` edges (64 by default) after the test starts, `alarm` rises at the `TIMEOUT`-th edge. A trip sampled on that last edge still counts as a pass.
- R8: Once `alarm` is high, it and `bus_clamp` stay high and `run_en`, `test_en` and `int_rst` stay low, whatever `ext_rst` and `sens_trip` do. Only a low `por_n` clears this state.
- R9: While `run_en` is high, an edge that samples `sens_trip` high drops `run_en` and raises `int_rst` and `bus_clamp`. This takes precedence over `ext_rst`.
- R10: While `run_en` is high and `sens_trip` is low, an edge that samples `ext_rst` high drops `run_en` and restarts the self-test with `test_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst | input | 1 | External reset request, active high |
| sens_trip | input | 1 | Sensor output, high when the sensed condition is reported |
| bus_rb | input | DATA_W | Readback of the clamped bus and control lines |
| int_rst | output | 1 | Internal core reset |
| test_en | output | 1 | Drives the sensor into self-test |
| bus_clamp | output | 1 | Forces the bus and control lines to zero |
| run_en | output | 1 | Lets the processor execute |
| alarm | output | 1 | Permanent tamper alarm |

## Verification
Several rules are checked on every cycle:
- the clamp covers the internal reset;
- a trip during the test or during execution leads into reset at the next edge;
- the alarm never clears;
- execution is only ever entered straight from reset with a clean readback.

Other behaviours need the bench's scenarios. These are the exact length of the reset window, the timeout falling on the 64th edge with a last-edge trip still passing, the idle state ignoring the sensor, and the retest started by an external reset during execution.

// File: rtl/sensor_reset_seq_pkg.sv
package sensor_reset_seq_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE   = 3'd0,
      SQ_PROBE  = 3'd1,
      SQ_HOLD   = 3'd2,
      SQ_CHECK  = 3'd3,
      SQ_LIVE   = 3'd4,
      SQ_TRAP   = 3'd5
   } seq_state_e;
endpackage

// File: rtl/sensor_reset_seq_count.sv
module sensor_reset_seq_count #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          por_n,
   input  logic          clr,
   output logic [CW-1:0] q
);
   localparam logic [CW-1:0] TOP = {CW{1'b1}};

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        q <= '0;
      else if (clr)      q <= '0;
      else if (q != TOP) q <= q + 1'b1;
   end
endmodule

// File: rtl/sensor_reset_seq_decode.sv
module sensor_reset_seq_decode
   import sensor_reset_seq_pkg::*;
#(
   parameter bit TRAP_CLAMP = 1'b1
) (
   input  seq_state_e st,
   output logic       int_rst,
   output logic       test_en,
   output logic       bus_clamp,
   output logic       run_en,
   output logic       alarm
);
   logic rst_phase;

   always_comb begin
      rst_phase = (st == SQ_HOLD) || (st == SQ_CHECK);
      int_rst   = rst_phase;
      test_en   = (st == SQ_PROBE);
      run_en    = (st == SQ_LIVE);
      alarm     = (st == SQ_TRAP);
   end

   generate
      if (TRAP_CLAMP) begin : g_trap_clamp
         assign bus_clamp = rst_phase || (st == SQ_TRAP);
      end else begin : g_rst_clamp
         assign bus_clamp = rst_phase;
      end
   endgenerate
endmodule

// File: rtl/sensor_reset_seq.sv
module sensor_reset_seq
   import sensor_reset_seq_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int TIMEOUT    = 64,
   parameter int RST_CYCLES = 4,
   parameter bit TRAP_CLAMP = 1'b1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              ext_rst,
   input  logic              sens_trip,
   input  logic [DATA_W-1:0] bus_rb,
   output logic              int_rst,
   output logic              test_en,
   output logic              bus_clamp,
   output logic              run_en,
   output logic              alarm
);
   localparam int SPAN = (TIMEOUT > RST_CYCLES) ? TIMEOUT : RST_CYCLES;
   localparam int CW   = $clog2(SPAN + 1);
   localparam logic [CW-1:0] T_LAST = CW'(TIMEOUT - 1);
   localparam logic [CW-1:0] R_LAST = CW'(RST_CYCLES - 1);

   initial begin
      if (DATA_W < 1)     $error("DATA_W must be at least 1");
      if (TIMEOUT < 2)    $error("TIMEOUT must be at least 2");
      if (RST_CYCLES < 1) $error("RST_CYCLES must be at least 1");
   end

   seq_state_e      st, st_nx;
   logic [CW-1:0]   cnt;
   logic            cnt_clr;

   always_comb begin
      st_nx = st;
      unique case (st)
         SQ_IDLE:  if (ext_rst) st_nx = SQ_PROBE;
         SQ_PROBE: begin
            if (sens_trip)            st_nx = SQ_HOLD;
            else if (cnt == T_LAST)   st_nx = SQ_TRAP;
         end
         SQ_HOLD:  if (cnt == R_LAST) st_nx = SQ_CHECK;
         SQ_CHECK: st_nx = (bus_rb == '0) ? SQ_LIVE : SQ_TRAP;
         SQ_LIVE: begin
            if (sens_trip)    st_nx = SQ_HOLD;
            else if (ext_rst) st_nx = SQ_PROBE;
         end
         SQ_TRAP:  st_nx = SQ_TRAP;
         default:  st_nx = SQ_TRAP;
      endcase
      cnt_clr = (st_nx != st);
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) st <= SQ_IDLE;
      else        st <= st_nx;
   end

   sensor_reset_seq_count #(.CW(CW)) u_cnt (
      .clk   (clk),
      .por_n (por_n),
      .clr   (cnt_clr),
      .q     (cnt)
   );

   sensor_reset_seq_decode #(.TRAP_CLAMP(TRAP_CLAMP)) u_dec (
      .st        (st),
      .int_rst   (int_rst),
      .test_en   (test_en),
      .bus_clamp (bus_clamp),
      .run_en    (run_en),
      .alarm     (alarm)
   );
endmodule

// File: rtl/sensor_reset_seq_chk.sv
module sensor_reset_seq_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              por_n,
   input logic              ext_rst,
   input logic              sens_trip,
   input logic [DATA_W-1:0] bus_rb,
   input logic              int_rst,
   input logic              test_en,
   input logic              bus_clamp,
   input logic              run_en,
   input logic              alarm
);
   AST_TEST_TRIP_RST: assert property (@(posedge clk) disable iff (!por_n)
      test_en && sens_trip |=> int_rst && !test_en); // R3
   AST_RST_CLAMPED: assert property (@(posedge clk) disable iff (!por_n)
      int_rst |-> bus_clamp); // R5
   AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!por_n)
      $rose(run_en) |-> $past(int_rst) && ($past(bus_rb) == '0)); // R6
   AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!por_n)
      alarm |=> alarm && bus_clamp && !run_en && !int_rst && !test_en); // R8
   AST_RUN_TRIP: assert property (@(posedge clk) disable iff (!por_n)
      run_en && sens_trip |=> int_rst && bus_clamp && !run_en); // R9
   AST_RUN_RETEST: assert property (@(posedge clk) disable iff (!por_n)
      run_en && !sens_trip && ext_rst |=> test_en && !run_en); // R10
endmodule

bind sensor_reset_seq sensor_reset_seq_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .ext_rst   (ext_rst),
   .sens_trip (sens_trip),
   .bus_rb    (bus_rb),
   .int_rst   (int_rst),
   .test_en   (test_en),
   .bus_clamp (bus_clamp),
   .run_en    (run_en),
   .alarm     (alarm)
);

// File: tb/tb_sensor_reset_seq.sv
module tb_sensor_reset_seq;
   logic       clk = 1'b0;
   logic       por_n = 1'b0;
   logic       ext_rst = 1'b0;
   logic       sens_trip = 1'b0;
   logic [7:0] bus_rb = 8'h00;
   logic       int_rst, test_en, bus_clamp, run_en, alarm;
   int         total = 0;
   int         bad = 0;

   always #2 clk = ~clk;

   sensor_reset_seq dut (
      .clk(clk), .por_n(por_n), .ext_rst(ext_rst), .sens_trip(sens_trip),
      .bus_rb(bus_rb), .int_rst(int_rst), .test_en(test_en),
      .bus_clamp(bus_clamp), .run_en(run_en), .alarm(alarm)
   );

   // {ext_rst, sens_trip, bus_rb[7:0], expect int_rst,test_en,clamp,run,alarm}
   localparam logic [14:0] VEC [0:16] = '{
      {1'b0, 1'b1, 8'hA5, 5'b00000},   // R1 idle ignores trip and bus
      {1'b1, 1'b0, 8'h00, 5'b01000},   // R2 test starts
      {1'b0, 1'b0, 8'h00, 5'b01000},   // R2 test continues, no reset
      {1'b0, 1'b1, 8'h00, 5'b10100},   // R3 trip raises int_rst
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R4
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R4
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R4
      {1'b0, 1'b0, 8'hFF, 5'b10100},   // R4 readback cycle, bus ignored here
      {1'b0, 1'b0, 8'h00, 5'b00010},   // R6 clean readback runs
      {1'b0, 1'b0, 8'h33, 5'b00010},   // R6 run holds
      {1'b1, 1'b1, 8'h00, 5'b10100},   // R9 trip beats ext_rst
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R4
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R4
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R4
      {1'b0, 1'b0, 8'h00, 5'b10100},   // R5 readback cycle clamped
      {1'b0, 1'b0, 8'h04, 5'b00101},   // R6 dirty readback alarms
      {1'b1, 1'b1, 8'h00, 5'b00101}    // R8 alarm ignores inputs
   };

   task automatic check(input logic [4:0] exp, input string req);
      logic [4:0] got;
      got = {int_rst, test_en, bus_clamp, run_en, alarm};
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: outputs got=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic step(input logic e, input logic t, input logic [7:0] b);
      ext_rst = e; sens_trip = t; bus_rb = b;
      @(posedge clk); #1;
   endtask

   task automatic power_up();
      por_n = 1'b0; ext_rst = 1'b0; sens_trip = 1'b0; bus_rb = 8'h00;
      repeat (2) @(posedge clk);
      #1 por_n = 1'b1;
      @(posedge clk); #1;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog: run did not end, got=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #1;
      check(5'b00000, "R1 during power-on reset");
      power_up();
      check(5'b00000, "R1 after power-on reset");

      for (int i = 0; i < 17; i++) begin
         step(VEC[i][14], VEC[i][13], VEC[i][12:5]);
         check(VEC[i][4:0], $sformatf("vector %0d", i));
      end

      // R8: only power-on reset clears the alarm
      power_up();
      check(5'b00000, "R8 por clears alarm");

      // R7: timeout after 64 silent edges
      step(1'b1, 1'b0, 8'h00);
      for (int k = 1; k < 64; k++) step(1'b0, 1'b0, 8'h00);
      check(5'b01000, "R7 still testing on edge 63");
      step(1'b0, 1'b0, 8'h00);
      check(5'b00101, "R7 alarm on edge 64");

      // R7: trip on the last edge still passes
      power_up();
      step(1'b1, 1'b0, 8'h00);
      for (int k = 1; k < 64; k++) step(1'b0, 1'b0, 8'h00);
      step(1'b0, 1'b1, 8'h00);
      check(5'b10100, "R7 trip on last edge passes");

      // R10: external reset during run restarts the test
      for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 8'h00);
      step(1'b0, 1'b0, 8'h00);
      check(5'b00010, "R10 reached run");
      step(1'b1, 1'b0, 8'h00);
      check(5'b01000, "R10 retest from run");
      step(1'b0, 1'b0, 8'h00);
      check(5'b01000, "R2 retest holds int_rst low");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule